// File: doc/BRIEF.md
# Interlock Unit for a Five-Stage Pipeline Without Bypass Paths

This block decides, cycle by cycle, whether the decode stage of an in-order IF/ID/EX/MEM/WB pipeline may hand its instruction to execute. The pipeline has no bypass network. An operand that an older instruction has not yet written back must therefore be waited for. The unit compares the decode-stage source register numbers with the destination numbers of the write-enabled instructions now in EX and MEM. When one of them matches, it freezes the program counter and the IF/ID register and sends an empty slot into EX. The register file writes in the first half of a cycle and reads in the second half. A producer that has reached WB therefore never holds up a reader in decode.

Branches resolve late, so every branch that leaves decode is followed by exactly one empty EX slot. During that cycle the fetch side holds still. A free-running counter records every cycle in which an empty slot was inserted, whatever the cause.

The datapath uses the three outputs directly: the PC enable, the IF/ID load enable, and a bubble flag that clears the ID/EX control bits.

Top module: `nofwd_hazard_unit`

## Requirements
- R1: After reset, pc_write and ifid_write are 1, idex_bubble is 0 and stall_count is 0.
- R2: If a used decode source equals the destination of a write-enabled instruction in EX, then in that cycle pc_write=0, ifid_write=0 and idex_bubble=1.
- R3: If a used decode source equals the destination of a write-enabled instruction in MEM, then in that cycle pc_write=0, ifid_write=0 and idex_bubble=1.
- R4: A producer that has left MEM causes no stall, so a reader placed two or more instructions after its producer issues without delay.
- R5: Register number 0 never creates a dependence, whether it appears as a source or as a destination.
- R6: A source whose used flag is 0, or a stage whose write-enable is 0, never creates a dependence.
- R7: A reader issued immediately after its producer waits exactly 2 bubble cycles. The producer's kind (load or ALU) does not change this.
- R8: A branch that leaves decode with no pending hazard is followed by exactly one bubble cycle. In that cycle pc_write=0 and ifid_write=0.
- R9: A branch that depends on the instruction right before it takes its 2 data bubbles first and then its 1 branch bubble, for 3 in total.
- R10: stall_count increases by exactly 1 in each cycle where idex_bubble=1 and is unchanged otherwise.
- R11: The loop body load, add-using-load, load, subtract-using-load, three immediate adds, and a branch on the last add repeats every 15 cycles. 7 of those cycles are bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1_addr | input | 5 | First source register number in decode |
| id_rs1_used | input | 1 | First source is actually read |
| id_rs2_addr | input | 5 | Second source register number in decode |
| id_rs2_used | input | 1 | Second source is actually read |
| id_is_branch | input | 1 | Decode holds a branch |
| ex_dst_addr | input | 5 | Destination register of the EX instruction |
| ex_dst_wen | input | 1 | EX instruction writes a register |
| mem_dst_addr | input | 5 | Destination register of the MEM instruction |
| mem_dst_wen | input | 1 | MEM instruction writes a register |
| pc_write | output | 1 | Program counter may advance |
| ifid_write | output | 1 | IF/ID register may load |
| idex_bubble | output | 1 | Zero the ID/EX control bits this cycle |
| stall_count | output | 32 | Number of bubble cycles since reset |

## Verification
The assertions assume that the EX and MEM inputs describe the instructions that actually left decode earlier. In particular, a bubble must reach EX with its write-enable cleared. The bench meets this with a small model of the ID, EX and MEM stage registers. The model advances only when the unit allows it and loads an empty slot whenever idex_bubble is high. The assertions also assume that id_is_branch is low in the cycle after a branch leaves decode, when decode holds the instruction that follows the branch. The programs the bench runs never place two branches back to back.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // reason for the current decode-stage hold
  typedef enum logic [1:0] {
    HOLD_NONE   = 2'd0,
    HOLD_DATA   = 2'd1,
    HOLD_BRANCH = 2'd2
  } hold_cause_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int AW         = 5,
  parameter int NUM_STAGES = 2
) (
  input  logic [AW-1:0] src,
  input  logic          src_used,
  input  logic [AW-1:0] dst      [NUM_STAGES],
  input  logic          dst_wen  [NUM_STAGES],
  output logic          hit
);
  logic [NUM_STAGES-1:0] stage_hit;
  logic                  src_live;

  // register zero is hardwired and never carries a dependence
  assign src_live = src_used && (src != '0);

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    assign stage_hit[s] = src_live && dst_wen[s] && (dst[s] != '0) && (dst[s] == src);
  end

  assign hit = |stage_hit;
endmodule

// File: rtl/hz_branch_tracker.sv
module hz_branch_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic branch_go,
  output logic pend
);
  logic pend_d;

  always_comb begin
    pend_d = branch_go && !pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  AST_BR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !pend); // R8
endmodule

// File: rtl/hz_stall_counter.sv
module hz_stall_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] count_d;
  logic         count_en;

  assign count_en = inc;

  always_comb begin
    count_d = count + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> count == $past(count) + W'(1)); // R10
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count)); // R10
endmodule

// File: rtl/nofwd_hazard_unit.sv
module nofwd_hazard_unit #(
  parameter int REG_AW = 5,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1_addr,
  input  logic              id_rs1_used,
  input  logic [REG_AW-1:0] id_rs2_addr,
  input  logic              id_rs2_used,
  input  logic              id_is_branch,
  input  logic [REG_AW-1:0] ex_dst_addr,
  input  logic              ex_dst_wen,
  input  logic [REG_AW-1:0] mem_dst_addr,
  input  logic              mem_dst_wen,
  output logic              pc_write,
  output logic              ifid_write,
  output logic              idex_bubble,
  output logic [CNT_W-1:0]  stall_count
);
  import hz_pkg::*;

  localparam int NUM_SRC    = 2;
  localparam int NUM_STAGES = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [REG_AW-1:0] src_addr [NUM_SRC];
  logic              src_used [NUM_SRC];
  logic [REG_AW-1:0] dst_addr [NUM_STAGES];
  logic              dst_wen  [NUM_STAGES];
  logic [NUM_SRC-1:0] src_hit;

  assign src_addr[0] = id_rs1_addr;
  assign src_addr[1] = id_rs2_addr;
  assign src_used[0] = id_rs1_used;
  assign src_used[1] = id_rs2_used;
  assign dst_addr[0] = ex_dst_addr;
  assign dst_addr[1] = mem_dst_addr;
  assign dst_wen[0]  = ex_dst_wen;
  assign dst_wen[1]  = mem_dst_wen;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    hz_src_match #(.AW(REG_AW), .NUM_STAGES(NUM_STAGES)) u_match (
      .src      (src_addr[i]),
      .src_used (src_used[i]),
      .dst      (dst_addr),
      .dst_wen  (dst_wen),
      .hit      (src_hit[i])
    );
  end

  logic        br_pend;
  logic        branch_go;
  hold_cause_e cause;
  logic        hold;

  always_comb begin
    if (br_pend)       cause = HOLD_BRANCH;
    else if (|src_hit) cause = HOLD_DATA;
    else               cause = HOLD_NONE;
  end

  assign hold        = (cause != HOLD_NONE);
  assign branch_go   = id_is_branch && !hold;
  assign pc_write    = !hold;
  assign ifid_write  = !hold;
  assign idex_bubble = hold;

  hz_branch_tracker u_branch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .branch_go (branch_go),
    .pend      (br_pend)
  );

  hz_stall_counter #(.W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (idex_bubble),
    .count (stall_count)
  );

  AST_EX_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ex_dst_wen && ex_dst_addr != '0 && id_rs1_used && id_rs1_addr == ex_dst_addr)
    |-> (idex_bubble && !pc_write && !ifid_write)); // R2
  AST_MEM_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_dst_wen && mem_dst_addr != '0 && id_rs2_used && id_rs2_addr == mem_dst_addr)
    |-> (idex_bubble && !pc_write && !ifid_write)); // R3
  AST_ZERO_FREE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (id_rs1_addr == '0 && id_rs2_addr == '0 && !br_pend) |-> !idex_bubble); // R5
  AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ex_dst_wen && !mem_dst_wen && !br_pend) |-> !idex_bubble); // R6
  AST_BR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (id_is_branch && pc_write) |=> idex_bubble); // R8
endmodule

// File: tb/nofwd_hazard_unit_bench.sv
`timescale 1ns/1ps
module nofwd_hazard_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  id_rs1_addr, id_rs2_addr, ex_dst_addr, mem_dst_addr;
  logic        id_rs1_used, id_rs2_used, id_is_branch, ex_dst_wen, mem_dst_wen;
  logic        pc_write, ifid_write, idex_bubble;
  logic [31:0] stall_count;

  always #4 clk = ~clk;

  nofwd_hazard_unit u_nofwd_hazard_unit (
    .clk(clk), .rst_n(rst_n),
    .id_rs1_addr(id_rs1_addr), .id_rs1_used(id_rs1_used),
    .id_rs2_addr(id_rs2_addr), .id_rs2_used(id_rs2_used),
    .id_is_branch(id_is_branch),
    .ex_dst_addr(ex_dst_addr), .ex_dst_wen(ex_dst_wen),
    .mem_dst_addr(mem_dst_addr), .mem_dst_wen(mem_dst_wen),
    .pc_write(pc_write), .ifid_write(ifid_write),
    .idex_bubble(idex_bubble), .stall_count(stall_count)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct packed {
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic       u1;
    logic       u2;
    logic       wen;
    logic       br;
  } ins_t;

  localparam ins_t NOP = '0;

  ins_t prog [16];
  int   plen;
  int   lstart;
  ins_t id_i, ex_i, mem_i;
  int   id_x;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic ins_t mk(input int rd, input int rs1, input int rs2,
                              input bit u1, input bit u2, input bit wen, input bit br);
    ins_t t;
    t.rd = 5'(rd); t.rs1 = 5'(rs1); t.rs2 = 5'(rs2);
    t.u1 = u1; t.u2 = u2; t.wen = wen; t.br = br;
    return t;
  endfunction

  function automatic int fidx(input int p);
    if (p < plen) return p;
    if (lstart >= 0) return lstart + (p - lstart) % (plen - lstart);
    return -1;
  endfunction

  task automatic drive();
    id_rs1_addr  = id_i.rs1;  id_rs1_used = id_i.u1;
    id_rs2_addr  = id_i.rs2;  id_rs2_used = id_i.u2;
    id_is_branch = id_i.br;
    ex_dst_addr  = ex_i.rd;   ex_dst_wen  = ex_i.wen;
    mem_dst_addr = mem_i.rd;  mem_dst_wen = mem_i.wen;
  endtask

  // drive a raw decode/EX/MEM picture and sample in the middle of the cycle
  task automatic apply(input ins_t d, input ins_t e, input ins_t m);
    @(posedge clk); #1;
    id_i = d; ex_i = e; mem_i = m;
    drive();
    @(negedge clk);
  endtask

  // stage-register model of the datapath, steered by the unit's outputs
  task automatic run_prog(input int ncyc, output int bubbles,
                          output int iter_len, output int iter_stalls);
    int pc;
    int t_prev;
    int b_prev;
    logic [31:0] cnt0;
    pc = 0; bubbles = 0; iter_len = 0; iter_stalls = 0; t_prev = -1; b_prev = 0;
    @(posedge clk); #1;
    id_i = NOP; id_x = -1; ex_i = NOP; mem_i = NOP;
    drive();
    @(negedge clk);
    cnt0 = stall_count;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      logic pw, bb;
      @(negedge clk);
      pw = pc_write; bb = idex_bubble;
      if (bb) bubbles++;
      if (!bb && lstart >= 0 && id_x == lstart) begin
        if (t_prev >= 0) begin
          iter_len    = cyc - t_prev;
          iter_stalls = bubbles - b_prev;
        end
        t_prev = cyc; b_prev = bubbles;
      end
      @(posedge clk); #1;
      mem_i = ex_i;
      ex_i  = bb ? NOP : id_i;
      if (pw) begin
        id_x = fidx(pc);
        id_i = (id_x >= 0) ? prog[id_x] : NOP;
        pc++;
      end
      drive();
    end
    @(negedge clk);
    chk("R10 counter delta equals bubble cycles", stall_count - cnt0, 32'(bubbles));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    id_i = NOP; ex_i = NOP; mem_i = NOP;
    drive();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pc_write", 32'(pc_write), 1);
    chk("R1 ifid_write", 32'(ifid_write), 1);
    chk("R1 idex_bubble", 32'(idex_bubble), 0);
    chk("R1 stall_count", stall_count, 0);
  endtask

  task automatic t_ex_match();
    apply(mk(0, 7, 0, 1, 0, 1, 0), mk(7, 0, 0, 0, 0, 1, 0), NOP);
    chk("R2 rs1 vs EX bubble", 32'(idex_bubble), 1);
    chk("R2 rs1 vs EX pc_write", 32'(pc_write), 0);
    chk("R2 rs1 vs EX ifid_write", 32'(ifid_write), 0);
    apply(mk(0, 0, 12, 0, 1, 1, 0), mk(12, 0, 0, 0, 0, 1, 0), NOP);
    chk("R2 rs2 vs EX bubble", 32'(idex_bubble), 1);
  endtask

  task automatic t_mem_match();
    apply(mk(0, 0, 9, 0, 1, 1, 0), mk(3, 0, 0, 0, 0, 1, 0), mk(9, 0, 0, 0, 0, 1, 0));
    chk("R3 rs2 vs MEM bubble", 32'(idex_bubble), 1);
    chk("R3 rs2 vs MEM pc_write", 32'(pc_write), 0);
    apply(mk(0, 31, 0, 1, 0, 1, 0), NOP, mk(31, 0, 0, 0, 0, 1, 0));
    chk("R3 rs1 vs MEM bubble", 32'(idex_bubble), 1);
  endtask

  task automatic t_zero_reg();
    apply(mk(0, 0, 0, 1, 1, 1, 0), mk(0, 0, 0, 0, 0, 1, 0), mk(0, 0, 0, 0, 0, 1, 0));
    chk("R5 register 0 no bubble", 32'(idex_bubble), 0);
    chk("R5 register 0 pc_write", 32'(pc_write), 1);
  endtask

  task automatic t_unused();
    apply(mk(0, 6, 6, 0, 0, 1, 0), mk(6, 0, 0, 0, 0, 1, 0), mk(6, 0, 0, 0, 0, 1, 0));
    chk("R6 unused source no bubble", 32'(idex_bubble), 0);
    apply(mk(0, 6, 8, 1, 1, 1, 0), mk(6, 0, 0, 0, 0, 0, 0), mk(8, 0, 0, 0, 0, 0, 0));
    chk("R6 non-writing stage no bubble", 32'(idex_bubble), 0);
    apply(mk(0, 6, 0, 1, 0, 1, 0), mk(5, 0, 0, 0, 0, 1, 0), mk(4, 0, 0, 0, 0, 1, 0));
    chk("R4 no matching stage no bubble", 32'(ifid_write), 1);
    apply(NOP, NOP, NOP);
  endtask

  task automatic t_back_to_back();
    int b, il, is;
    // ALU producer, then reader of its result
    plen = 2; lstart = -1;
    prog[0] = mk(7, 1, 2, 1, 1, 1, 0);
    prog[1] = mk(8, 7, 0, 1, 0, 1, 0);
    run_prog(12, b, il, is);
    chk("R7 ALU producer costs 2 bubbles", 32'(b), 2);
    // load producer, then reader of the loaded value
    prog[0] = mk(5, 1, 0, 1, 0, 1, 0);
    prog[1] = mk(4, 4, 5, 1, 1, 1, 0);
    run_prog(12, b, il, is);
    chk("R7 load producer costs 2 bubbles", 32'(b), 2);
  endtask

  task automatic t_distance_two();
    int b, il, is;
    plen = 4; lstart = -1;
    prog[0] = mk(5, 1, 0, 1, 0, 1, 0);
    prog[1] = mk(9, 2, 0, 1, 0, 1, 0);
    prog[2] = mk(10, 3, 0, 1, 0, 1, 0);
    prog[3] = mk(4, 4, 5, 1, 1, 1, 0);
    run_prog(14, b, il, is);
    chk("R4 reader two instructions later no bubble", 32'(b), 0);
  endtask

  task automatic t_branch();
    int b, il, is;
    plen = 2; lstart = -1;
    prog[0] = mk(0, 1, 2, 1, 1, 0, 1);
    prog[1] = mk(6, 1, 0, 1, 0, 1, 0);
    run_prog(12, b, il, is);
    chk("R8 independent branch costs 1 bubble", 32'(b), 1);
    prog[0] = mk(3, 3, 0, 1, 0, 1, 0);
    prog[1] = mk(0, 3, 0, 1, 1, 0, 1);
    run_prog(12, b, il, is);
    chk("R9 dependent branch costs 3 bubbles", 32'(b), 3);
  endtask

  task automatic t_loop();
    int b, il, is;
    plen = 10; lstart = 2;
    prog[0] = mk(3, 0, 0, 1, 0, 1, 0);   // r3 = 100
    prog[1] = mk(4, 0, 0, 1, 1, 1, 0);   // r4 = 0
    prog[2] = mk(5, 1, 0, 1, 0, 1, 0);   // load r5
    prog[3] = mk(4, 4, 5, 1, 1, 1, 0);   // r4 += r5
    prog[4] = mk(6, 2, 0, 1, 0, 1, 0);   // load r6
    prog[5] = mk(4, 4, 6, 1, 1, 1, 0);   // r4 -= r6
    prog[6] = mk(1, 1, 0, 1, 0, 1, 0);   // r1 += 4
    prog[7] = mk(2, 2, 0, 1, 0, 1, 0);   // r2 += 4
    prog[8] = mk(3, 3, 0, 1, 0, 1, 0);   // r3 -= 1
    prog[9] = mk(0, 3, 0, 1, 1, 0, 1);   // branch on r3
    run_prog(90, b, il, is);
    chk("R11 loop iteration cycles", 32'(il), 15);
    chk("R11 loop iteration bubbles", 32'(is), 7);
  endtask

  initial begin
    t_reset();
    t_ex_match();
    t_mem_match();
    t_zero_reg();
    t_unused();
    t_back_to_back();
    t_distance_two();
    t_branch();
    t_loop();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule